// File: doc/BRIEF.md
# Word-Register I2C Sensor Slave

This block is the serial front end of a sensor controller. An external host reaches a bank of 16-bit registers over a two-wire I2C bus. Each register is selected by an 8-bit command code. Every access moves one whole word, low byte first and high byte second. The block samples SCL and SDA with the system clock through two-flop synchronisers and finds start, stop and repeated-start conditions on the synchronised lines. It matches the 7-bit slave address, takes the command byte, and then either receives or returns the data word. It pulls the open-drain data line low to acknowledge.

Codes 0x00 to 0x07 hold the configuration words, and the core reads them from a flat output bus. Codes 0x08 to 0x0A return measurement words supplied by the core. Code 0x0B carries a sticky event-flag byte in its upper half. Code 0x0C returns a fixed identity word. The core gets a one-cycle strobe for each committed write and for each read. Reading the flag word clears the flags, so the interrupt logic in the core can rely on read-to-clear.

Top module: `wordreg_i2c_slave`

## Requirements
- R1: After reset SDA is released (sda_oe_o = 0), both strobes are low, flags_o is 0x00, configuration words 0x00 and 0x03 hold 0x0001, and every other configuration word holds 0x0000.
- R2: An address byte whose upper seven bits equal 0x60 is acknowledged. Any other address gets no acknowledge, and SDA stays released for every byte until the next Start.
- R3: A write (Start, 0xC0, code, low byte, high byte, Stop) acknowledges every byte and stores {high, low} in configuration word `code`. wr_stb_o pulses for exactly one cycle with wr_cmd_o = code and wr_data_o = {high, low}, and cfg_o changes only in the cycle after such a pulse.
- R4: A write is committed only at the end of the acknowledge clock of the high byte. A Stop after only the low byte leaves the register unchanged and produces no strobe.
- R5: A read (Start, 0xC0, code, repeated Start, 0xC1) returns the low byte first and then the high byte, MSB first. The master acknowledges the low byte and leaves the high byte unacknowledged.
- R6: Read mapping: codes 0x00-0x07 return the stored configuration word. Codes 0x08, 0x09 and 0x0A return meas_i[15:0], [31:16] and [47:32]. Code 0x0B returns {flags, 0x00}. Code 0x0C returns 0x0186. Any code above 0x0C returns 0x0000.
- R7: A write to any code from 0x08 upward is acknowledged but changes nothing and produces no wr_stb_o pulse.
- R8: When the read address byte is acknowledged, rd_stb_o pulses for exactly one cycle with rd_cmd_o equal to the command code sent before the repeated Start.
- R9: A bit set on flag_set_i for one cycle sets the matching flag, and the flag stays set. A read of code 0x0B returns the flags as they were before the read, then clears all of them. A flag set in the same cycle as the clear survives it.
- R10: SDA is only ever pulled low while the synchronised SCL is low, and a Start or a Stop always releases it.
- R11: Any data byte that follows the high byte of a write is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| meas_i | input | NUM_MEAS*16 | Measurement words from the core for codes 0x08 upward |
| flag_set_i | input | 8 | Per-bit event pulses that set the sticky flags |
| cfg_o | output | NUM_RW*16 | All configuration words, word n at bits [16n+15:16n] |
| flags_o | output | 8 | Current sticky flag byte |
| wr_stb_o | output | 1 | One-cycle pulse for a committed configuration write |
| wr_cmd_o | output | 8 | Command code of the committed write |
| wr_data_o | output | 16 | Word written |
| rd_stb_o | output | 1 | One-cycle pulse when a read word starts |
| rd_cmd_o | output | 8 | Command code being read |

## Verification
The bench targets a Stop that arrives after only the low byte. A design that commits early would show a strobe and a changed word there. It also targets a wrong address: a slave that still acknowledges would pull SDA low on the address byte or on the later bytes. It reads the flag word while the core raises a new event in the clearing cycle, so a design that lets the clear win loses that event on the next read. It also tries writes to read-only and identity codes, reads past the last code, and sends an extra byte after a complete write. The byte order and the snapshot-before-clear value are checked byte by byte on the bus.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_DLO,
        K_DHI
    } rx_kind_e;

    typedef struct packed {
        bus_st_e     st;
        rx_kind_e    kind;
        logic [3:0]  bitcnt;
        logic [7:0]  sh;
        logic [7:0]  cmd;
        logic [7:0]  lo;
        logic [15:0] txw;
        logic [7:0]  txsh;
        logic        txhi;
        logic        go_tx;
        logic        commit;
        logic        mack;
        logic        oe;
        logic        wr_stb;
        logic [7:0]  wr_cmd;
        logic [15:0] wr_data;
        logic        rd_stb;
        logic [7:0]  rd_cmd;
    } ctl_t;

endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] prev_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign prev_o[g] = prev_q;
    end

endmodule

// File: rtl/i2cw_reg_bank.sv
module i2cw_reg_bank #(
    parameter int                     NUM_RW    = 8,
    parameter int                     NUM_MEAS  = 3,
    parameter logic [NUM_RW*16-1:0]   CFG_RESET = '0,
    parameter logic [15:0]            ID_WORD   = 16'h0186
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [7:0]             wr_cmd_i,
    input  logic [15:0]            wr_data_i,
    input  logic [7:0]             rd_cmd_i,
    input  logic                   flag_clr_i,
    input  logic [7:0]             flag_set_i,
    input  logic [NUM_MEAS*16-1:0] meas_i,
    output logic [15:0]            rd_word_o,
    output logic [NUM_RW*16-1:0]   cfg_o,
    output logic [7:0]             flags_o
);

    localparam logic [7:0] FLAG_CODE = 8'(NUM_RW + NUM_MEAS);
    localparam logic [7:0] ID_CODE   = 8'(NUM_RW + NUM_MEAS + 1);

    logic [15:0] cfg_q [NUM_RW];
    logic [7:0]  flags_d, flags_q;

    for (genvar g = 0; g < NUM_RW; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= CFG_RESET[g*16 +: 16];
            end else if (wr_en_i && (wr_cmd_i == 8'(g))) begin
                cfg_q[g] <= wr_data_i;
            end
        end
        assign cfg_o[g*16 +: 16] = cfg_q[g];
    end

    // A new event in the clearing cycle is kept.
    always_comb begin
        flags_d = flag_set_i | (flag_clr_i ? 8'h00 : flags_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= 8'h00;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    always_comb begin
        rd_word_o = 16'h0000;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_cmd_i == 8'(i)) rd_word_o = cfg_q[i];
        end
        for (int i = 0; i < NUM_MEAS; i++) begin
            if (rd_cmd_i == 8'(NUM_RW + i)) rd_word_o = meas_i[i*16 +: 16];
        end
        if (rd_cmd_i == FLAG_CODE) rd_word_o = {flags_q, 8'h00};
        if (rd_cmd_i == ID_CODE)   rd_word_o = ID_WORD;
    end

endmodule

// File: rtl/wordreg_i2c_slave.sv
module wordreg_i2c_slave
    import i2cw_pkg::*;
#(
    parameter logic [6:0]           SLAVE_ADDR = 7'h60,
    parameter int                   NUM_RW     = 8,
    parameter int                   NUM_MEAS   = 3,
    parameter logic [NUM_RW*16-1:0] CFG_RESET  = 128'h0000_0000_0000_0000_0001_0000_0000_0001,
    parameter logic [15:0]          ID_WORD    = 16'h0186,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [NUM_MEAS*16-1:0] meas_i,
    input  logic [7:0]             flag_set_i,
    output logic [NUM_RW*16-1:0]   cfg_o,
    output logic [7:0]             flags_o,
    output logic                   wr_stb_o,
    output logic [7:0]             wr_cmd_o,
    output logic [15:0]            wr_data_o,
    output logic                   rd_stb_o,
    output logic [7:0]             rd_cmd_o
);

    localparam logic [7:0] FLAG_CODE = 8'(NUM_RW + NUM_MEAS);

    logic [1:0]  lvl, prev;
    logic        scl_s, sda_s, scl_p, sda_p;
    logic        scl_rise, scl_fall, start_det, stop_det;
    logic [15:0] rd_word;
    ctl_t        d, q;

    i2cw_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    assign scl_s = lvl[0];
    assign sda_s = lvl[1];
    assign scl_p = prev[0];
    assign sda_p = prev[1];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    i2cw_reg_bank #(
        .NUM_RW    (NUM_RW),
        .NUM_MEAS  (NUM_MEAS),
        .CFG_RESET (CFG_RESET),
        .ID_WORD   (ID_WORD)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (q.wr_stb),
        .wr_cmd_i   (q.wr_cmd),
        .wr_data_i  (q.wr_data),
        .rd_cmd_i   (q.cmd),
        .flag_clr_i (q.rd_stb && (q.rd_cmd == FLAG_CODE)),
        .flag_set_i (flag_set_i),
        .meas_i     (meas_i),
        .rd_word_o  (rd_word),
        .cfg_o      (cfg_o),
        .flags_o    (flags_o)
    );

    always_comb begin
        d        = q;
        d.wr_stb = 1'b0;
        d.rd_stb = 1'b0;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st     = ST_RX;
            d.kind   = K_ADDR;
            d.bitcnt = 4'd0;
            d.oe     = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && (q.bitcnt < 4'd8)) begin
                        d.sh     = {q.sh[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && (q.bitcnt == 4'd8)) begin
                        d.st     = ST_RXACK;
                        d.oe     = 1'b1;
                        d.commit = 1'b0;
                        d.go_tx  = 1'b0;
                        case (q.kind)
                            K_ADDR: begin
                                if (q.sh[7:1] == SLAVE_ADDR) begin
                                    d.kind = K_CMD;
                                    if (q.sh[0]) begin
                                        d.go_tx  = 1'b1;
                                        d.rd_stb = 1'b1;
                                        d.rd_cmd = q.cmd;
                                        d.txw    = rd_word;
                                    end
                                end else begin
                                    d.st = ST_SKIP;
                                    d.oe = 1'b0;
                                end
                            end
                            K_CMD: begin
                                d.cmd  = q.sh;
                                d.kind = K_DLO;
                            end
                            K_DLO: begin
                                d.lo   = q.sh;
                                d.kind = K_DHI;
                            end
                            default: d.commit = 1'b1;
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        d.bitcnt = 4'd0;
                        if (q.commit) begin
                            d.wr_stb  = (q.cmd < 8'(NUM_RW));
                            d.wr_cmd  = q.cmd;
                            d.wr_data = {q.sh, q.lo};
                            d.st      = ST_SKIP;
                            d.oe      = 1'b0;
                        end else if (q.go_tx) begin
                            d.st   = ST_TX;
                            d.txhi = 1'b0;
                            d.txsh = q.txw[7:0];
                            d.oe   = ~q.txw[7];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.st = ST_TXACK;
                            d.oe = 1'b0;
                        end else begin
                            d.txsh = {q.txsh[6:0], 1'b0};
                            d.oe   = ~q.txsh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack && !q.txhi) begin
                            d.st     = ST_TX;
                            d.txhi   = 1'b1;
                            d.txsh   = q.txw[15:8];
                            d.oe     = ~q.txw[15];
                            d.bitcnt = 4'd0;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o  = q.oe;
    assign wr_stb_o  = q.wr_stb;
    assign wr_cmd_o  = q.wr_cmd;
    assign wr_data_o = q.wr_data;
    assign rd_stb_o  = q.rd_stb;
    assign rd_cmd_o  = q.rd_cmd;

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int NUM_RW   = 8,
    parameter int NUM_MEAS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_s,
    input logic                 start_det,
    input logic                 stop_det,
    input logic                 sda_oe_o,
    input logic                 wr_stb_o,
    input logic [7:0]           wr_cmd_o,
    input logic                 rd_stb_o,
    input logic [7:0]           rd_cmd_o,
    input logic [7:0]           flags_o,
    input logic [7:0]           flag_set_i,
    input logic [NUM_RW*16-1:0] cfg_o
);

    localparam logic [7:0] FLAG_CODE = 8'(NUM_RW + NUM_MEAS);

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    assert_cfg_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(wr_stb_o));

    assert_wr_rw_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (wr_cmd_o < 8'(NUM_RW)));

    assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |=> !rd_stb_o);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_o && (rd_cmd_o == FLAG_CODE)) |=> (flags_o == $past(flag_set_i)));

endmodule

bind wordreg_i2c_slave i2cw_checker #(
    .NUM_RW   (NUM_RW),
    .NUM_MEAS (NUM_MEAS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb_o),
    .wr_cmd_o   (wr_cmd_o),
    .rd_stb_o   (rd_stb_o),
    .rd_cmd_o   (rd_cmd_o),
    .flags_o    (flags_o),
    .flag_set_i (flag_set_i),
    .cfg_o      (cfg_o)
);

// File: tb/tb_wordreg_i2c_slave.sv
module tb_wordreg_i2c_slave;

    localparam int Q = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         bus_sda;
    logic         sda_oe_o;
    logic [47:0]  meas_i = 48'hBEEF_5A3C_0F21;
    logic [7:0]   flag_set_i = 8'h00;
    logic [127:0] cfg_o;
    logic [7:0]   flags_o;
    logic         wr_stb_o, rd_stb_o;
    logic [7:0]   wr_cmd_o, rd_cmd_o;
    logic [15:0]  wr_data_o;

    int checks = 0;
    int failures = 0;
    logic [23:0] exp_wr[$];
    logic [7:0]  exp_rd[$];

    always #10 clk = ~clk;

    assign bus_sda = m_sda & ~sda_oe_o;

    wordreg_i2c_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (bus_sda),
        .sda_oe_o   (sda_oe_o),
        .meas_i     (meas_i),
        .flag_set_i (flag_set_i),
        .cfg_o      (cfg_o),
        .flags_o    (flags_o),
        .wr_stb_o   (wr_stb_o),
        .wr_cmd_o   (wr_cmd_o),
        .wr_data_o  (wr_data_o),
        .rd_stb_o   (rd_stb_o),
        .rd_cmd_o   (rd_cmd_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = ~bus_sda; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = bus_sda; tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~give_ack; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic write_word(input string req, input logic [7:0] cmd,
                              input logic [15:0] w, input logic expect_commit);
        logic ack;
        bus_start();
        send_byte(8'hC0, ack);  chk({req, " R2 addr ack"}, 32'(ack), 32'd1);
        send_byte(cmd, ack);    chk({req, " R3 cmd ack"}, 32'(ack), 32'd1);
        send_byte(w[7:0], ack); chk({req, " R3 low ack"}, 32'(ack), 32'd1);
        if (expect_commit) exp_wr.push_back({cmd, w});
        send_byte(w[15:8], ack); chk({req, " R3 high ack"}, 32'(ack), 32'd1);
        bus_stop();
        chk({req, " R10 released after stop"}, 32'(sda_oe_o), 32'd0);
    endtask

    task automatic read_word(input string req, input logic [7:0] cmd, input logic [15:0] exp);
        logic ack;
        logic [7:0] lo, hi;
        bus_start();
        send_byte(8'hC0, ack); chk({req, " R2 addr ack"}, 32'(ack), 32'd1);
        send_byte(cmd, ack);   chk({req, " R5 cmd ack"}, 32'(ack), 32'd1);
        bus_rstart();
        exp_rd.push_back(cmd);
        send_byte(8'hC1, ack); chk({req, " R5 read addr ack"}, 32'(ack), 32'd1);
        recv_byte(1'b1, lo);
        recv_byte(1'b0, hi);
        bus_stop();
        chk({req, " R5 low byte"}, 32'(lo), 32'(exp[7:0]));
        chk({req, " R5 high byte"}, 32'(hi), 32'(exp[15:8]));
    endtask

    task automatic pulse_flags(input logic [7:0] v);
        flag_set_i = v; tick(1);
        flag_set_i = 8'h00; tick(1);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wr_stb_o) begin
                if (exp_wr.size() == 0) begin
                    chk("R3/R4/R7 unexpected write strobe", {8'h0, wr_cmd_o, wr_data_o}, 32'hFFFF_FFFF);
                end else begin
                    logic [23:0] e;
                    e = exp_wr.pop_front();
                    chk("R3 write strobe cmd/data", {8'h0, wr_cmd_o, wr_data_o}, {8'h0, e});
                end
            end
            if (rst_n && rd_stb_o) begin
                if (exp_rd.size() == 0) begin
                    chk("R8 unexpected read strobe", 32'(rd_cmd_o), 32'hFFFF_FFFF);
                end else begin
                    logic [7:0] r;
                    r = exp_rd.pop_front();
                    chk("R8 read strobe cmd", 32'(rd_cmd_o), 32'(r));
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic ack;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1 reset state
        chk("R1 sda released", 32'(sda_oe_o), 32'd0);
        chk("R1 strobes low", {30'd0, wr_stb_o, rd_stb_o}, 32'd0);
        chk("R1 flags clear", 32'(flags_o), 32'd0);
        for (int i = 0; i < 8; i++) begin
            chk("R1 cfg default", 32'(cfg_o[i*16 +: 16]), (i == 0 || i == 3) ? 32'd1 : 32'd0);
        end
        read_word("R1 code0", 8'h00, 16'h0001);
        read_word("R1 code3", 8'h03, 16'h0001);

        // R3 writes and readback
        write_word("R3 w1", 8'h01, 16'hA55A, 1'b1);
        read_word("R3 r1", 8'h01, 16'hA55A);
        write_word("R3 w7", 8'h07, 16'h1234, 1'b1);
        chk("R3 cfg word 7", 32'(cfg_o[112 +: 16]), 32'h1234);
        read_word("R6 r7", 8'h07, 16'h1234);

        // R4 partial write discarded
        bus_start();
        send_byte(8'hC0, ack);
        send_byte(8'h05, ack);
        send_byte(8'h77, ack);
        bus_stop();
        tick(4);
        chk("R4 partial write no change", 32'(cfg_o[80 +: 16]), 32'h0);
        read_word("R4 r5", 8'h05, 16'h0000);

        // R2 wrong address
        bus_start();
        send_byte(8'hC2, ack); chk("R2 mismatch addr nack", 32'(ack), 32'd0);
        send_byte(8'h01, ack); chk("R2 mismatch cmd nack", 32'(ack), 32'd0);
        send_byte(8'h00, ack); chk("R2 mismatch data nack", 32'(ack), 32'd0);
        bus_stop();
        read_word("R2 r1 unchanged", 8'h01, 16'hA55A);

        // R6 read-only mapping
        read_word("R6 meas0", 8'h08, 16'h0F21);
        read_word("R6 meas1", 8'h09, 16'h5A3C);
        read_word("R6 meas2", 8'h0A, 16'hBEEF);
        read_word("R6 id", 8'h0C, 16'h0186);
        read_word("R6 unmapped", 8'h20, 16'h0000);

        // R7 writes to read-only codes ignored
        write_word("R7 w9", 8'h09, 16'hFFFF, 1'b0);
        write_word("R7 wC", 8'h0C, 16'h0000, 1'b0);
        read_word("R7 r9", 8'h09, 16'h5A3C);
        read_word("R7 rC", 8'h0C, 16'h0186);

        // R9 sticky flags, read to clear
        pulse_flags(8'h41);
        pulse_flags(8'h02);
        chk("R9 flags sticky", 32'(flags_o), 32'h43);
        read_word("R9 flag read", 8'h0B, 16'h4300);
        chk("R9 flags cleared", 32'(flags_o), 32'h00);
        read_word("R9 flag reread", 8'h0B, 16'h0000);
        pulse_flags(8'h04);
        fork
            read_word("R9 snapshot", 8'h0B, 16'h0400);
            begin
                do @(negedge clk); while (!rd_stb_o);
                flag_set_i = 8'h10;
                @(negedge clk);
                flag_set_i = 8'h00;
            end
        join
        chk("R9 set wins over clear", 32'(flags_o), 32'h10);
        read_word("R9 survivor", 8'h0B, 16'h1000);

        // R11 extra byte after full write
        bus_start();
        send_byte(8'hC0, ack);
        send_byte(8'h02, ack);
        send_byte(8'hCD, ack);
        exp_wr.push_back({8'h02, 16'h9ACD});
        send_byte(8'h9A, ack); chk("R3 high ack before extra", 32'(ack), 32'd1);
        send_byte(8'h55, ack); chk("R11 extra byte nack", 32'(ack), 32'd0);
        bus_stop();
        chk("R10 released after extra", 32'(sda_oe_o), 32'd0);
        read_word("R11 r2", 8'h02, 16'h9ACD);

        tick(20);
        chk("R3 pending writes drained", 32'(exp_wr.size()), 32'd0);
        chk("R8 pending reads drained", 32'(exp_rd.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule